// File: doc/BRIEF.md
# Run/Pause/Reset State Controller

This block is the small control machine that decides whether a serial-bus master datapath is idle, running or frozen. Software places a request for one of three states on a register-style write port. The controller does not switch at once. It lowers a valid flag and holds it low through a fixed settling handshake: a set number of interface-clock cycles, then a set number of master-clock ticks. It then commits the new state and raises valid again. A request is taken only while valid is high.

The committed state drives the datapath enables. In run the command sequencer may consume entries. In pause the command FIFO still accepts writes but nothing is consumed, so queued contents survive. In reset both FIFOs and all operational and error flags are held clear. A software-reset strobe forces the reset state at once, from any state and at any time. Writing the reset state while an error is pending produces a one-cycle pulse that clears the error interrupt. A master-generator-ready flag tells software when the controller has settled after a hardware or software reset.

Top module: `run_state_ctrl`

## Requirements
- R1: The state output uses code 0 for reset, 1 for run and 3 for pause, and never shows 2. After hardware reset the state is 0, valid is low and master-ready is low.
- R2: After hardware reset is released, valid and master-ready both rise at the end of one settling handshake. The handshake is IF_CYCLES clocks followed by M_CYCLES cycles with `mclk_tick` high.
- R3: A state write is accepted when `st_wr_en` is high, valid is high, the code is 0, 1 or 3, and `soft_rst` is low. From the next cycle valid stays low for IF_CYCLES clocks plus M_CYCLES master ticks, which is 6 cycles at the defaults with the tick held high. The state keeps its old value throughout. The new state appears in the same cycle that valid rises.
- R4: A state write made while valid is low is ignored, and so is a write of code 2. Neither lowers valid nor changes the state.
- R5: In the cycle after `soft_rst` is high, the state is 0 and valid and master-ready are low, and any transition in flight is discarded. A new settling handshake then raises both flags. `soft_rst` wins over a state write in the same cycle.
- R6: `seq_take_en` is high only while the state is run (1) and valid is high.
- R7: `cmd_wr_en` is high while the state is run or pause. In pause, `seq_take_en` and `fifo_flush` are both low, so queued entries are kept.
- R8: `fifo_flush` is high exactly while the state is reset (0). This includes the settling handshake that follows a software reset.
- R9: `err_clr` is a one-cycle pulse in the cycle after an accepted write of code 0 made while `err_pending` is high. It stays low otherwise.
- R10: Master-ready stays high through ordinary accepted state transitions. Only hardware reset or `soft_rst` lowers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mclk_tick | input | 1 | One-cycle enable marking a master-clock period |
| st_wr_en | input | 1 | State request write strobe |
| st_wr_code | input | 2 | Requested state code |
| soft_rst | input | 1 | Software reset strobe |
| err_pending | input | 1 | An error interrupt is pending |
| cur_state | output | 2 | Committed state code |
| state_valid | output | 1 | High when no transition is in progress |
| mgen_ready | output | 1 | Master generator settled and ready |
| seq_take_en | output | 1 | Sequencer may consume command entries |
| cmd_wr_en | output | 1 | Command FIFO may be written |
| fifo_flush | output | 1 | Hold FIFOs and flags clear |
| err_clr | output | 1 | Pulse clearing the error interrupt |

## Verification
The hardest case to reach from the ports is a software reset that lands part-way through a transition. That includes the master-tick phase of the handshake, where the committed target must be thrown away and no stale commit may follow. Directed stimulus fires the strobe a few cycles after an accepted run request. Random stimulus then mixes sparse master ticks, writes made while valid is low, the illegal code and occasional strobes, so that these collisions happen in every phase of the handshake. The output is compared each cycle against a reference model in the bench.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   localparam int CODE_W = 2;
   typedef enum logic [CODE_W-1:0] {
      RSC_RESET = 2'd0,
      RSC_RUN   = 2'd1,
      RSC_PAUSE = 2'd3
   } rsc_state_e;

   function automatic logic code_legal(input logic [CODE_W-1:0] c);
      return (c != 2'd2);
   endfunction
endpackage

// File: rtl/rsc_settle_timer.sv
module rsc_settle_timer #(
   parameter int IF_CYCLES = 3,
   parameter int M_CYCLES  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic mclk_tick,
   output logic busy,
   output logic done
);
   localparam int IW = $clog2(IF_CYCLES + 1);
   localparam int MW = $clog2(M_CYCLES + 1);
   localparam logic [IW-1:0] IF_LOAD = IW'(IF_CYCLES);
   localparam logic [MW-1:0] M_LOAD  = MW'(M_CYCLES);

   logic          in_m;
   logic [IW-1:0] if_left;
   logic [MW-1:0] m_left;

   assign done = busy && in_m && mclk_tick && (m_left == MW'(1)) && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b1;
         in_m    <= 1'b0;
         if_left <= IF_LOAD;
         m_left  <= M_LOAD;
      end else if (start) begin
         busy    <= 1'b1;
         in_m    <= 1'b0;
         if_left <= IF_LOAD;
      end else if (busy) begin
         if (!in_m) begin
            if (if_left == IW'(1)) begin
               in_m   <= 1'b1;
               m_left <= M_LOAD;
            end else begin
               if_left <= if_left - IW'(1);
            end
         end else if (mclk_tick) begin
            if (m_left == MW'(1)) busy <= 1'b0;
            else                  m_left <= m_left - MW'(1);
         end
      end
   end
endmodule

// File: rtl/rsc_state_keeper.sv
module rsc_state_keeper
   import rsc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              err_pending,
   input  logic              settled,
   input  logic              done,
   output logic              start,
   output logic [CODE_W-1:0] state_q,
   output logic              mgen_q,
   output logic              err_clr_q
);
   logic              accept;
   logic [CODE_W-1:0] target_q;

   assign accept = wr_en && settled && code_legal(wr_code) && !soft_rst;
   assign start  = soft_rst || accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RSC_RESET;
         target_q  <= RSC_RESET;
         mgen_q    <= 1'b0;
         err_clr_q <= 1'b0;
      end else begin
         err_clr_q <= accept && (wr_code == RSC_RESET) && err_pending;
         if (soft_rst) begin
            state_q  <= RSC_RESET;
            target_q <= RSC_RESET;
            mgen_q   <= 1'b0;
         end else begin
            if (accept) target_q <= wr_code;
            if (done) begin
               state_q <= target_q;
               mgen_q  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/run_state_ctrl.sv
module run_state_ctrl #(
   parameter int IF_CYCLES       = 3,
   parameter int M_CYCLES        = 3,
   parameter bit FREEZE_IN_SETTLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mclk_tick,
   input  logic       st_wr_en,
   input  logic [1:0] st_wr_code,
   input  logic       soft_rst,
   input  logic       err_pending,
   output logic [1:0] cur_state,
   output logic       state_valid,
   output logic       mgen_ready,
   output logic       seq_take_en,
   output logic       cmd_wr_en,
   output logic       fifo_flush,
   output logic       err_clr
);
   import rsc_pkg::*;

   if (IF_CYCLES < 1) begin : g_bad_if
      $error("IF_CYCLES must be at least 1");
   end
   if (M_CYCLES < 1) begin : g_bad_m
      $error("M_CYCLES must be at least 1");
   end

   logic start, busy, done;

   rsc_settle_timer #(.IF_CYCLES(IF_CYCLES), .M_CYCLES(M_CYCLES)) i_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .mclk_tick(mclk_tick),
      .busy(busy), .done(done)
   );

   assign state_valid = !busy;

   rsc_state_keeper i_keeper (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(st_wr_en),
      .wr_code(st_wr_code), .err_pending(err_pending), .settled(!busy),
      .done(done), .start(start), .state_q(cur_state), .mgen_q(mgen_ready),
      .err_clr_q(err_clr)
   );

   if (FREEZE_IN_SETTLE) begin : g_freeze
      assign seq_take_en = (cur_state == RSC_RUN) && !busy;
   end else begin : g_nofreeze
      assign seq_take_en = (cur_state == RSC_RUN);
   end

   assign cmd_wr_en  = (cur_state == RSC_RUN) || (cur_state == RSC_PAUSE);
   assign fifo_flush = (cur_state == RSC_RESET);
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       st_wr_en,
   input logic [1:0] st_wr_code,
   input logic       soft_rst,
   input logic       err_pending,
   input logic [1:0] cur_state,
   input logic       state_valid,
   input logic       mgen_ready,
   input logic       seq_take_en,
   input logic       cmd_wr_en,
   input logic       fifo_flush,
   input logic       err_clr
);
   logic req_ok;
   assign req_ok = st_wr_en && state_valid && (st_wr_code != 2'd2) && !soft_rst;

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cur_state != 2'd2); // R1
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      req_ok |=> !state_valid); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_valid && !req_ok && !soft_rst) |=> (state_valid && $stable(cur_state))); // R4
   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (cur_state == 2'd0 && !state_valid && !mgen_ready)); // R5
   AST_SEQ_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      seq_take_en |-> (cur_state == 2'd1 && state_valid)); // R6
   AST_FLUSH_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush |-> !cmd_wr_en); // R8
   AST_ERR_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |-> ($past(err_pending) && $past(st_wr_en) && $past(st_wr_code) == 2'd0)); // R9
   AST_MGEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mgen_ready && !soft_rst) |=> mgen_ready); // R10
endmodule

bind run_state_ctrl rsc_checker i_chk (
   .clk(clk), .rst_n(rst_n), .st_wr_en(st_wr_en), .st_wr_code(st_wr_code),
   .soft_rst(soft_rst), .err_pending(err_pending), .cur_state(cur_state),
   .state_valid(state_valid), .mgen_ready(mgen_ready), .seq_take_en(seq_take_en),
   .cmd_wr_en(cmd_wr_en), .fifo_flush(fifo_flush), .err_clr(err_clr)
);

// File: tb/test_run_state_ctrl.sv
`timescale 1ns/1ps
module test_run_state_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mclk_tick = 1'b1;
   logic       st_wr_en = 1'b0;
   logic [1:0] st_wr_code = 2'd0;
   logic       soft_rst = 1'b0;
   logic       err_pending = 1'b0;
   logic [1:0] cur_state;
   logic       state_valid, mgen_ready, seq_take_en, cmd_wr_en, fifo_flush, err_clr;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   run_state_ctrl i_run_state_ctrl (
      .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick), .st_wr_en(st_wr_en),
      .st_wr_code(st_wr_code), .soft_rst(soft_rst), .err_pending(err_pending),
      .cur_state(cur_state), .state_valid(state_valid), .mgen_ready(mgen_ready),
      .seq_take_en(seq_take_en), .cmd_wr_en(cmd_wr_en), .fifo_flush(fifo_flush),
      .err_clr(err_clr)
   );

   // reference model built from the requirements
   bit      r_busy, r_inm, r_mgen, r_errc;
   int      r_ifl, r_ml;
   logic [1:0] r_state, r_tgt;

   always @(posedge clk or negedge rst_n) begin
      bit acc, dn;
      if (!rst_n) begin
         r_busy = 1; r_inm = 0; r_ifl = 3; r_ml = 3;
         r_state = 0; r_tgt = 0; r_mgen = 0; r_errc = 0;
      end else begin
         acc = st_wr_en && !r_busy && st_wr_code != 2'd2 && !soft_rst;
         dn  = r_busy && r_inm && mclk_tick && r_ml == 1 && !(soft_rst || acc);
         r_errc = acc && st_wr_code == 2'd0 && err_pending;
         if (soft_rst) begin
            r_state = 0; r_tgt = 0; r_mgen = 0;
         end else begin
            if (acc) r_tgt = st_wr_code;
            if (dn) begin r_state = r_tgt; r_mgen = 1; end
         end
         if (soft_rst || acc) begin
            r_busy = 1; r_inm = 0; r_ifl = 3;
         end else if (r_busy) begin
            if (!r_inm) begin
               if (r_ifl == 1) begin r_inm = 1; r_ml = 3; end
               else r_ifl--;
            end else if (mclk_tick) begin
               if (r_ml == 1) r_busy = 0; else r_ml--;
            end
         end
      end
   end

   function automatic bit exp_seq();
      return r_state == 2'd1 && !r_busy;
   endfunction
   function automatic bit exp_wr();
      return r_state == 2'd1 || r_state == 2'd3;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic model_cmp();
      chk(cur_state == r_state, "R3 state vs model", cur_state, r_state);
      chk(state_valid == !r_busy, "R3 valid vs model", state_valid, !r_busy);
      chk(mgen_ready == r_mgen, "R10 mgen vs model", mgen_ready, r_mgen);
      chk(seq_take_en == exp_seq(), "R6 seq vs model", seq_take_en, exp_seq());
      chk(cmd_wr_en == exp_wr(), "R7 wr vs model", cmd_wr_en, exp_wr());
      chk(fifo_flush == (r_state == 2'd0), "R8 flush vs model", fifo_flush, r_state == 2'd0);
      chk(err_clr == r_errc, "R9 err_clr vs model", err_clr, r_errc);
   endtask

   task automatic write_code(input logic [1:0] c);
      st_wr_en = 1; st_wr_code = c;
      step();
      st_wr_en = 0;
   endtask

   task automatic count_low(output int n);
      n = 0;
      while (!state_valid && n < 100) begin n++; step(); end
   endtask

   initial begin
      int n;
      void'($urandom(32'h5eed));
      repeat (2) @(negedge clk);
      chk(cur_state == 0, "R1 reset state", cur_state, 0);
      chk(!state_valid, "R1 valid low in reset", state_valid, 0);
      chk(!mgen_ready, "R1 mgen low in reset", mgen_ready, 0);
      rst_n = 1;
      count_low(n);
      chk(n == 6, "R2 power-up settle cycles", n, 6);
      chk(mgen_ready, "R2 mgen after settle", mgen_ready, 1);
      chk(fifo_flush && !cmd_wr_en, "R8 flush in reset", fifo_flush, 1);

      write_code(2'd1);
      chk(cur_state == 0, "R3 old state during settle", cur_state, 0);
      count_low(n);
      chk(n == 6, "R3 transition settle cycles", n, 6);
      chk(cur_state == 1, "R3 run committed", cur_state, 1);
      chk(seq_take_en, "R6 seq enabled in run", seq_take_en, 1);
      chk(mgen_ready, "R10 mgen kept", mgen_ready, 1);

      write_code(2'd3);
      chk(!seq_take_en, "R6 seq frozen while settling", seq_take_en, 0);
      write_code(2'd1);
      count_low(n);
      chk(cur_state == 3, "R4 busy write ignored", cur_state, 3);
      chk(cmd_wr_en && !seq_take_en && !fifo_flush, "R7 pause keeps writes",
          {cmd_wr_en, seq_take_en, fifo_flush}, 3'b100);

      write_code(2'd2);
      chk(state_valid && cur_state == 3, "R4 code 2 ignored", state_valid, 1);

      err_pending = 1;
      write_code(2'd0);
      chk(err_clr, "R9 err_clr pulse", err_clr, 1);
      step();
      chk(!err_clr, "R9 err_clr one cycle", err_clr, 0);
      err_pending = 0;
      count_low(n);
      chk(cur_state == 0 && fifo_flush, "R8 reset committed", cur_state, 0);

      write_code(2'd1);
      step(); step(); step();
      soft_rst = 1; step(); soft_rst = 0;
      chk(cur_state == 0 && !state_valid && !mgen_ready, "R5 soft reset mid settle",
          {cur_state, state_valid, mgen_ready}, 0);
      count_low(n);
      chk(n == 6 && cur_state == 0 && mgen_ready, "R5 settle after soft reset", n, 6);

      // random phase compared against the model every cycle
      repeat (3000) begin
         mclk_tick   = ($urandom % 3) == 0;
         st_wr_en    = ($urandom % 4) == 0;
         st_wr_code  = 2'($urandom);
         soft_rst    = ($urandom % 40) == 0;
         err_pending = $urandom;
         step();
         model_cmp();
      end
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule